// File: doc/BRIEF.md
# Four-State Bitwise Logic Unit

This unit applies one bitwise logic operation per issue to two vectors of four-state elements and registers the outcome. Each element is carried as a two-bit code, so a vector of `WIDTH` elements occupies `2*WIDTH` wires. The unit supports AND, OR, NAND, NOR, XOR, XNOR, invert, blend, and two reductions (OR and NOR) that collapse the first operand to one four-state element.

The logic follows four-valued rules. A dominant 0 (for AND) or 1 (for OR) decides the result even when the other input is unknown. A high-impedance input counts as unknown everywhere except in blend, where two matching elements pass through unchanged, high-impedance included. The reduction is formed from the operand as presented, before anything is registered, so a caller may later write it back over the same storage.

A caller presents an opcode and two operands with `in_valid`. One clock later the result appears with a one-cycle `out_valid` pulse. Between issues the outputs hold their value.

Top module: `fsl_unit`

## Requirements
- R1: Element code is 00=0, 01=1, 10=z, 11=x. Opcode 0 (AND): a 0 on either input gives 0, 1 with 1 gives 1, and every other pair gives x.
- R2: Opcode 1 (OR): a 1 on either input gives 1, 0 with 0 gives 0, and every other pair gives x.
- R3: Opcodes 2 (NAND) and 3 (NOR) give the inverse of AND and OR, with x wherever AND or OR gives x.
- R4: Opcodes 4 (XOR) and 5 (XNOR) give the exclusive-or or its inverse when both inputs are 0 or 1, and x when either input is x or z.
- R5: Opcode 6 (invert) acts on operand A only: 0 gives 1, 1 gives 0, and both x and z give x. Operand B has no effect.
- R6: Opcode 7 (blend): when the two elements carry the same code (0, 1, z or x), the result is that code. Otherwise the result is x. No other vector opcode ever produces z.
- R7: Opcode 8 (OR reduction of A): the reduction bit is 1 if any element is 1. Otherwise it is x if any element is x or z, and 0 if all elements are 0. It is never z.
- R8: Opcode 9 (NOR reduction of A): the reduction bit is the inverse of the OR reduction (x stays x). It is never z.
- R9: A result is registered one clock after an issue with `in_valid` high. `out_valid` pulses for exactly that cycle and is low one cycle after any cycle without `in_valid`.
- R10: While `in_valid` is low, `res_vec` and `red_bit` hold their last values whatever `op`, `a_vec` and `b_vec` do.
- R11: Under reset, `out_valid` is 0, `res_vec` is all 00 and `red_bit` is 00.
- R12: For vector opcodes 0 to 7, `red_bit` reads 00. For reduction opcodes 8 and 9, `res_vec` reads all 00.
- R13: Opcodes 10 to 15 give x (11) in every element of `res_vec` and in `red_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Issue strobe |
| op | input | 4 | Operation code |
| a_vec | input | 2*WIDTH | Operand A, two bits per element |
| b_vec | input | 2*WIDTH | Operand B, two bits per element |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| res_vec | output | 2*WIDTH | Registered vector result |
| red_bit | output | 2 | Registered reduction result |

## Verification
The properties assume that `in_valid` is driven to a defined 0 or 1 on every clock. They also assume that while `in_valid` is low, changes on `op` and the operands are allowed and must be ignored. The timing properties compare an issue with the following cycle only, so they accept back-to-back issues as well as idle gaps. The stimulus drives every input only on falling edges. It covers all sixteen element pairs for each vector opcode by packing two pairs-per-lane sweeps into full-width vectors. It places unknown, high-impedance and dominant codes at both the lowest and the highest lane for the reductions. It changes the inputs freely during idle cycles with `in_valid` held low.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  localparam logic [1:0] FS_0 = 2'b00;
  localparam logic [1:0] FS_1 = 2'b01;
  localparam logic [1:0] FS_Z = 2'b10;
  localparam logic [1:0] FS_X = 2'b11;

  localparam logic [3:0] OP_AND   = 4'd0;
  localparam logic [3:0] OP_OR    = 4'd1;
  localparam logic [3:0] OP_NAND  = 4'd2;
  localparam logic [3:0] OP_NOR   = 4'd3;
  localparam logic [3:0] OP_XOR   = 4'd4;
  localparam logic [3:0] OP_XNOR  = 4'd5;
  localparam logic [3:0] OP_INV   = 4'd6;
  localparam logic [3:0] OP_BLEND = 4'd7;
  localparam logic [3:0] OP_ROR   = 4'd8;
  localparam logic [3:0] OP_RNOR  = 4'd9;

  // an element is known when it is 0 or 1 (upper code bit clear)
  function automatic logic fs_known(input logic [1:0] v);
    return ~v[1];
  endfunction

  function automatic logic [1:0] fs_and(input logic [1:0] a, input logic [1:0] b);
    if (a == FS_0 || b == FS_0) return FS_0;
    if (a == FS_1 && b == FS_1) return FS_1;
    return FS_X;
  endfunction

  function automatic logic [1:0] fs_or(input logic [1:0] a, input logic [1:0] b);
    if (a == FS_1 || b == FS_1) return FS_1;
    if (a == FS_0 && b == FS_0) return FS_0;
    return FS_X;
  endfunction

  function automatic logic [1:0] fs_not(input logic [1:0] a);
    if (fs_known(a)) return {1'b0, ~a[0]};
    return FS_X;
  endfunction

  function automatic logic [1:0] fs_xor(input logic [1:0] a, input logic [1:0] b);
    if (fs_known(a) && fs_known(b)) return {1'b0, a[0] ^ b[0]};
    return FS_X;
  endfunction

  function automatic logic [1:0] fs_blend(input logic [1:0] a, input logic [1:0] b);
    if (a == b) return a;
    return FS_X;
  endfunction
endpackage

// File: rtl/fsl_lane.sv
module fsl_lane
  import fsl_pkg::*;
(
  input  logic [3:0] op,
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [1:0] r
);
  always_comb begin
    case (op)
      OP_AND:   r = fs_and(a, b);
      OP_OR:    r = fs_or(a, b);
      OP_NAND:  r = fs_not(fs_and(a, b));
      OP_NOR:   r = fs_not(fs_or(a, b));
      OP_XOR:   r = fs_xor(a, b);
      OP_XNOR:  r = fs_not(fs_xor(a, b));
      OP_INV:   r = fs_not(a);
      OP_BLEND: r = fs_blend(a, b);
      default:  r = FS_X;
    endcase
  end
endmodule

// File: rtl/fsl_reduce.sv
module fsl_reduce
  import fsl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [2*WIDTH-1:0] vec,
  output logic [1:0]         or_bit,
  output logic [1:0]         nor_bit
);
  logic [1:0] acc;

  always_comb begin
    acc = FS_0;
    for (int i = 0; i < WIDTH; i++) begin
      acc = fs_or(acc, vec[2*i +: 2]);
    end
  end

  assign or_bit  = acc;
  assign nor_bit = fs_not(acc);
endmodule

// File: rtl/fsl_unit.sv
module fsl_unit
  import fsl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [3:0]         op,
  input  logic [2*WIDTH-1:0] a_vec,
  input  logic [2*WIDTH-1:0] b_vec,
  output logic               out_valid,
  output logic [2*WIDTH-1:0] res_vec,
  output logic [1:0]         red_bit
);
  localparam int VW = 2 * WIDTH;

  logic [VW-1:0] lane_res;
  logic [1:0]    red_or;
  logic [1:0]    red_nor;
  logic          is_vec_op;
  logic          is_red_op;
  logic [VW-1:0] next_res;
  logic [1:0]    next_red;

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    fsl_lane u_lane (
      .op (op),
      .a  (a_vec[2*g +: 2]),
      .b  (b_vec[2*g +: 2]),
      .r  (lane_res[2*g +: 2])
    );
  end

  fsl_reduce #(.WIDTH(WIDTH)) u_reduce (
    .vec     (a_vec),
    .or_bit  (red_or),
    .nor_bit (red_nor)
  );

  assign is_vec_op = (op <= OP_BLEND);
  assign is_red_op = (op == OP_ROR) || (op == OP_RNOR);

  always_comb begin
    if (is_vec_op) begin
      next_res = lane_res;
      next_red = FS_0;
    end else if (is_red_op) begin
      next_res = '0;
      next_red = (op == OP_ROR) ? red_or : red_nor;
    end else begin
      next_res = {WIDTH{FS_X}};
      next_red = FS_X;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
      red_bit   <= FS_0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec <= next_res;
        red_bit <= next_red;
      end
    end
  end
endmodule

// File: rtl/fsl_unit_chk.sv
module fsl_unit_chk
  import fsl_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [3:0]         op,
  input logic [2*WIDTH-1:0] a_vec,
  input logic [2*WIDTH-1:0] b_vec,
  input logic               out_valid,
  input logic [2*WIDTH-1:0] res_vec,
  input logic [1:0]         red_bit
);
  logic res_has_z;
  always_comb begin
    res_has_z = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (res_vec[2*i +: 2] == FS_Z) res_has_z = 1'b1;
    end
  end

  p_issue_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_vec) && $stable(red_bit)));
  p_and_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_AND && a_vec == '0) |=> (res_vec == '0));
  p_xor_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_XOR && a_vec == {WIDTH{FS_X}}) |=> (res_vec == {WIDTH{FS_X}}));
  p_no_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != OP_BLEND) |=> !res_has_z);
  p_or_dominant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ROR && a_vec[1:0] == FS_1) |=> (red_bit == FS_1));
  p_red_not_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
    red_bit != FS_Z);
  p_vec_red_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op <= OP_BLEND) |=> (red_bit == FS_0));
endmodule

bind fsl_unit fsl_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .a_vec     (a_vec),
  .b_vec     (b_vec),
  .out_valid (out_valid),
  .res_vec   (res_vec),
  .red_bit   (red_bit)
);

// File: tb/tb_fsl_unit.sv
module tb_fsl_unit;
  localparam int W  = 8;
  localparam int VW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    op;
  logic [VW-1:0] a_vec, b_vec;
  logic          out_valid;
  logic [VW-1:0] res_vec;
  logic [1:0]    red_bit;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fsl_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .a_vec(a_vec), .b_vec(b_vec),
    .out_valid(out_valid), .res_vec(res_vec), .red_bit(red_bit)
  );

  typedef struct {
    logic [VW-1:0] res;
    logic [1:0]    red;
    string         tag;
  } exp_t;
  exp_t sb[$];
  logic [VW-1:0] last_res = '0;
  logic [1:0]    last_red = 2'b00;

  // rank model: 0 -> 0, unknown -> 1, 1 -> 2 (AND = min, OR = max, NOT = 2-r)
  function automatic int rk(input logic [1:0] e);
    if (e == 2'b00) return 0;
    if (e == 2'b01) return 2;
    return 1;
  endfunction
  function automatic logic [1:0] unrk(input int r);
    if (r == 0) return 2'b00;
    if (r == 2) return 2'b01;
    return 2'b11;
  endfunction
  function automatic int mn(input int x, input int y); return (x < y) ? x : y; endfunction
  function automatic int mx(input int x, input int y); return (x > y) ? x : y; endfunction

  function automatic logic [1:0] model_elem(input logic [3:0] o, input logic [1:0] x, input logic [1:0] y);
    int rx = rk(x);
    int ry = rk(y);
    int xo;
    xo = (rx == 1 || ry == 1) ? 1 : ((rx == ry) ? 0 : 2);
    case (o)
      4'd0: return unrk(mn(rx, ry));
      4'd1: return unrk(mx(rx, ry));
      4'd2: return unrk(2 - mn(rx, ry));
      4'd3: return unrk(2 - mx(rx, ry));
      4'd4: return unrk(xo);
      4'd5: return unrk(2 - xo);
      4'd6: return unrk(2 - rx);
      4'd7: return (x == y) ? x : 2'b11;
      default: return 2'b11;
    endcase
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [3:0] o, input logic [VW-1:0] a, input logic [VW-1:0] b);
    exp_t e;
    int r;
    @(negedge clk);
    in_valid = 1'b1; op = o; a_vec = a; b_vec = b;
    e.tag = op_tag(o);
    if (o <= 4'd7) begin
      for (int i = 0; i < W; i++) e.res[2*i +: 2] = model_elem(o, a[2*i +: 2], b[2*i +: 2]);
      e.red = 2'b00;
    end else if (o <= 4'd9) begin
      e.res = '0;
      r = 0;
      for (int i = 0; i < W; i++) r = mx(r, rk(a[2*i +: 2]));
      e.red = (o == 4'd8) ? unrk(r) : unrk(2 - r);
    end else begin
      e.res = '1;
      e.red = 2'b11;
    end
    sb.push_back(e);
  endtask

  // monitor: compares each registered result against the queue head
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected out_valid", {VW{1'b0}}, {VW{1'b0}});
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_vec == e.res, (e.tag == "R7" || e.tag == "R8") ? "R12 res" : e.tag, res_vec, e.res);
        check(red_bit == e.red, (e.tag == "R7" || e.tag == "R8" || e.tag == "R13") ? e.tag : "R12 red",
              {{(VW-2){1'b0}}, red_bit}, {{(VW-2){1'b0}}, e.red});
        last_res = e.res;
        last_red = e.red;
      end
    end
  end

  function automatic logic [VW-1:0] fill(input logic [1:0] e);
    return {W{e}};
  endfunction

  initial begin
    logic [VW-1:0] va, vb, v;
    rst_n = 1'b0; in_valid = 1'b0; op = '0; a_vec = '0; b_vec = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && res_vec == '0 && red_bit == 2'b00, "R11 in reset",
          res_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && res_vec == '0 && red_bit == 2'b00, "R11 after release",
          res_vec, '0);

    // R1..R6: every element pair for every vector opcode, two halves per op
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 2; k++) begin
        for (int i = 0; i < W; i++) begin
          int p = k * 8 + i;
          va[2*i +: 2] = p[3:2];
          vb[2*i +: 2] = p[1:0];
        end
        send(4'(o), va, vb);
      end
    end
    // R5: invert with B varied must match invert with B zero
    send(4'd6, 16'hE41B, 16'hFFFF);
    send(4'd6, 16'hE41B, 16'h0000);
    // R6: blend keeps matching z
    send(4'd7, fill(2'b10), fill(2'b10));
    // R1, R4 full-width unknown cases
    send(4'd0, '0, fill(2'b11));
    send(4'd4, fill(2'b11), 16'h5555);
    // random vector traffic
    for (int n = 0; n < 24; n++) send(4'(n % 8), VW'($urandom), VW'($urandom));

    // R7 / R8 reductions
    for (int o = 8; o < 10; o++) begin
      send(4'(o), '0, '0);
      v = '0; v[1:0] = 2'b11;           send(4'(o), v, '1);
      v = '0; v[VW-1 -: 2] = 2'b10;     send(4'(o), v, '0);
      v = fill(2'b11); v[VW-1 -: 2] = 2'b01; send(4'(o), v, '0);
      v = fill(2'b10); v[1:0] = 2'b01;  send(4'(o), v, '0);
      send(4'(o), fill(2'b01), '0);
      for (int n = 0; n < 6; n++) send(4'(o), VW'($urandom), VW'($urandom));
    end
    // R13 reserved codes
    for (int o = 10; o < 16; o++) send(4'(o), VW'($urandom), VW'($urandom));

    // back-to-back then idle, R9 drain
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R9 results outstanding", VW'(sb.size()), '0);

    // R10: inputs move while idle
    for (int n = 0; n < 6; n++) begin
      op = 4'(n); a_vec = VW'($urandom); b_vec = VW'($urandom);
      @(negedge clk);
      check(out_valid == 1'b0, "R9 idle out_valid", {{(VW-1){1'b0}}, out_valid}, '0);
      check(res_vec == last_res && red_bit == last_red, "R10 hold", res_vec, last_res);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule